// File: doc/BRIEF.md
# E1 Maintenance Timer Status Generator

This block produces one status byte of timing and persistence flags for an E1 receive path. A single-cycle millisecond strobe, derived elsewhere from the 2.048 MHz line clock, is its only timebase. Two heartbeat bits divide that strobe down to half-second and one-second toggles. A CRC-4 alignment bit toggles every millisecond, and once multiframe alignment is reached it is locked to the receive multiframe sync pulse. Two more bits follow the expiry pulses of the 8 ms and 400 ms CRC-4 search timers.

The low three bits are persistence flags for line maintenance. Keep-alive reports an AIS condition that has held for 100 ms. Timer-one reports a loss of frame sync that has held for 100 ms. Timer-two reports frame sync that has held for 10 ms. The two timers are coupled: timer-two setting clears timer-one, and non-normal frames clear timer-two. In freerun mode the heartbeat bits and their divider are frozen.

Frame alignment, AIS detection and CRC-4 checking happen upstream. This block only times the flags they produce.

Top module: `e1_maint_timer_status`

## Requirements
- R1: After reset all eight bits of `tmr_status` are 0.
- R2: With `freerun` low, bit 7 toggles on every HALF_SEC_MS-th `ms_tick` (default 500), that is every 0.5 s.
- R3: Bit 6 toggles exactly when bit 7 goes from 1 to 0, so it toggles every 1 s and its edges line up with those of bit 7.
- R4: While `freerun` is high, bits 7 and 6 and the tick count behind them stay unchanged. Counting resumes from the held count when `freerun` drops.
- R5: While `crc_mf_aligned` is low, bit 3 toggles on every `ms_tick`.
- R6: While `crc_mf_aligned` is high, `crc_mf_sync` forces bit 3 to 1, even if `ms_tick` is high in the same cycle. A tick without a sync pulse toggles bit 3.
- R7: Bit 5 toggles on each `srch400_expire` pulse and bit 4 toggles on each `srch8_expire` pulse.
- R8: Bit 2 (keep-alive) sets on the KA_MS-th consecutive tick (default 100) taken while `ais_active` is high. It clears on the clock edge after `ais_active` goes low. A low on `ais_active` restarts the count.
- R9: Bit 1 (timer-one) sets on the T1_MS-th consecutive tick (default 100) taken while `frame_sync_ok` is low. A high on `frame_sync_ok` restarts the count. Bit 1 clears on the edge where bit 0 sets.
- R10: Bit 0 (timer-two) sets on the T2_MS-th consecutive tick (default 10) taken while `frame_sync_ok` is high and `nonnormal_frame` is low. It clears, and its count restarts, on any cycle with `nonnormal_frame` high.
- R11: Bit positions are: 7 one-second, 6 two-second, 5 400 ms search, 4 8 ms search, 3 CRC-4 alignment, 2 keep-alive, 1 timer-one, 0 timer-two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| freerun | input | 1 | Freerun mode; freezes the heartbeat bits |
| frame_sync_ok | input | 1 | Terminal frame synchronisation held |
| nonnormal_frame | input | 1 | Non-normal operational frames being received |
| ais_active | input | 1 | AIS status from the detector |
| crc_mf_aligned | input | 1 | CRC-4 multiframe alignment achieved |
| crc_mf_sync | input | 1 | Receive CRC-4 multiframe sync pulse |
| srch8_expire | input | 1 | 8 ms CRC-4 search timer expiry pulse |
| srch400_expire | input | 1 | 400 ms CRC-4 search timer expiry pulse |
| tmr_status | output | 8 | Timer status word |

## Verification
The bound checker watches, on every cycle, the local rules that link inputs to bits. These cover:
- freerun holding the heartbeat pair,
- bit 6 moving only on a falling bit 7,
- the alignment bit toggling or being forced by sync,
- the search bits toggling,
- keep-alive, timer-one and timer-two clearing on their conditions,
- keep-alive never standing without a full AIS run.

Only the bench scenarios can show the counted behaviours: the exact 500- and 1000-tick heartbeat periods, the count held across freerun, the 100- and 10-tick thresholds, and the restart of a persistence count after a short drop of its condition.

// File: rtl/tmr_stat_pkg.sv
`timescale 1ns/1ps
package tmr_stat_pkg;
   localparam int unsigned STAT_W    = 8;
   localparam int unsigned B_ONE_SEC = 7;
   localparam int unsigned B_TWO_SEC = 6;
   localparam int unsigned B_S400    = 5;
   localparam int unsigned B_S8      = 4;
   localparam int unsigned B_ALIGN   = 3;
   localparam int unsigned B_KALIVE  = 2;
   localparam int unsigned B_TMR1    = 1;
   localparam int unsigned B_TMR2    = 0;

   typedef logic [STAT_W-1:0] stat_word_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit > 1) ? $clog2(limit + 1) : 1;
   endfunction
endpackage

// File: rtl/tmr_heartbeat.sv
`timescale 1ns/1ps
module tmr_heartbeat #(
   parameter int unsigned HALF_MS = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic hold,
   output logic one_sec,
   output logic two_sec
);
   localparam int unsigned CW = (HALF_MS > 1) ? $clog2(HALF_MS) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_MS - 1);

   logic [CW-1:0] ms_cnt;

   generate
      if (HALF_MS < 1) begin : g_bad
         $error("tmr_heartbeat: HALF_MS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_cnt  <= '0;
         one_sec <= 1'b0;
         two_sec <= 1'b0;
      end else if (tick && !hold) begin
         if (ms_cnt == LAST) begin
            ms_cnt  <= '0;
            one_sec <= ~one_sec;
            if (one_sec) begin
               two_sec <= ~two_sec;
            end
         end else begin
            ms_cnt <= ms_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tmr_crc_flags.sv
`timescale 1ns/1ps
module tmr_crc_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic aligned,
   input  logic mf_sync,
   input  logic s8_exp,
   input  logic s400_exp,
   output logic align_bit,
   output logic s8_bit,
   output logic s400_bit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         align_bit <= 1'b0;
      end else if (aligned && mf_sync) begin
         align_bit <= 1'b1;
      end else if (tick) begin
         align_bit <= ~align_bit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s8_bit   <= 1'b0;
         s400_bit <= 1'b0;
      end else begin
         if (s8_exp)   s8_bit   <= ~s8_bit;
         if (s400_exp) s400_bit <= ~s400_bit;
      end
   end
endmodule

// File: rtl/tmr_persist.sv
`timescale 1ns/1ps
module tmr_persist
   import tmr_stat_pkg::*;
#(
   parameter int unsigned LIMIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic qual,
   output logic hit
);
   generate
      if (LIMIT < 1) begin : g_bad
         $error("tmr_persist: LIMIT must be at least 1");
      end else if (LIMIT == 1) begin : g_single
         logic done;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     done <= 1'b0;
            else if (!qual) done <= 1'b0;
            else if (tick)  done <= 1'b1;
         end
         assign hit = tick && qual && !done;
      end else begin : g_count
         localparam int unsigned CW = cnt_width(LIMIT);
         localparam logic [CW-1:0] TOP  = CW'(LIMIT);
         localparam logic [CW-1:0] NEAR = CW'(LIMIT - 1);
         logic [CW-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  run <= '0;
            else if (!qual)              run <= '0;
            else if (tick && run != TOP) run <= run + 1'b1;
         end
         assign hit = tick && qual && (run == NEAR);
      end
   endgenerate
endmodule

// File: rtl/e1_maint_timer_status.sv
`timescale 1ns/1ps
module e1_maint_timer_status
   import tmr_stat_pkg::*;
#(
   parameter int unsigned HALF_SEC_MS = 500,
   parameter int unsigned KA_MS       = 100,
   parameter int unsigned T1_MS       = 100,
   parameter int unsigned T2_MS       = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ms_tick,
   input  logic       freerun,
   input  logic       frame_sync_ok,
   input  logic       nonnormal_frame,
   input  logic       ais_active,
   input  logic       crc_mf_aligned,
   input  logic       crc_mf_sync,
   input  logic       srch8_expire,
   input  logic       srch400_expire,
   output logic [7:0] tmr_status
);
   generate
      if (KA_MS < 1 || T1_MS < 1 || T2_MS < 1 || HALF_SEC_MS < 1) begin : g_bad
         $error("e1_maint_timer_status: all timer lengths must be at least 1");
      end
   endgenerate

   logic one_sec, two_sec, align_bit, s8_bit, s400_bit;
   logic ka_hit, t1_hit, t2_hit;
   logic klve_q, t1_q, t2_q;
   stat_word_t word;

   tmr_heartbeat #(.HALF_MS(HALF_SEC_MS)) u_hb (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .hold(freerun),
      .one_sec(one_sec), .two_sec(two_sec)
   );

   tmr_crc_flags u_crc (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .aligned(crc_mf_aligned),
      .mf_sync(crc_mf_sync), .s8_exp(srch8_expire), .s400_exp(srch400_expire),
      .align_bit(align_bit), .s8_bit(s8_bit), .s400_bit(s400_bit)
   );

   tmr_persist #(.LIMIT(KA_MS)) u_ka (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .qual(ais_active), .hit(ka_hit)
   );

   tmr_persist #(.LIMIT(T1_MS)) u_t1 (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .qual(!frame_sync_ok), .hit(t1_hit)
   );

   tmr_persist #(.LIMIT(T2_MS)) u_t2 (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick),
      .qual(frame_sync_ok && !nonnormal_frame), .hit(t2_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         klve_q <= 1'b0;
         t1_q   <= 1'b0;
         t2_q   <= 1'b0;
      end else begin
         if (!ais_active)  klve_q <= 1'b0;
         else if (ka_hit)  klve_q <= 1'b1;

         if (t2_hit)       t1_q <= 1'b0;
         else if (t1_hit)  t1_q <= 1'b1;

         if (nonnormal_frame) t2_q <= 1'b0;
         else if (t2_hit)     t2_q <= 1'b1;
      end
   end

   always_comb begin
      word            = '0;
      word[B_ONE_SEC] = one_sec;
      word[B_TWO_SEC] = two_sec;
      word[B_S400]    = s400_bit;
      word[B_S8]      = s8_bit;
      word[B_ALIGN]   = align_bit;
      word[B_KALIVE]  = klve_q;
      word[B_TMR1]    = t1_q;
      word[B_TMR2]    = t2_q;
   end

   assign tmr_status = word;
endmodule

// File: rtl/e1_maint_timer_status_chk.sv
`timescale 1ns/1ps
module e1_maint_timer_status_chk #(
   parameter int unsigned KA_MS = 100
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ms_tick,
   input logic       freerun,
   input logic       nonnormal_frame,
   input logic       ais_active,
   input logic       crc_mf_aligned,
   input logic       crc_mf_sync,
   input logic       srch8_expire,
   input logic       srch400_expire,
   input logic [7:0] tmr_status
);
   localparam int unsigned KW = (KA_MS > 1) ? $clog2(KA_MS + 1) : 1;
   localparam logic [KW-1:0] KTOP = KW'(KA_MS);
   logic [KW-1:0] ais_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ais_run <= '0;
      else if (!ais_active)               ais_run <= '0;
      else if (ms_tick && ais_run != KTOP) ais_run <= ais_run + 1'b1;
   end

   AST_FREERUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      freerun |=> tmr_status[7:6] == $past(tmr_status[7:6])); // R4
   AST_TWO_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_status[6] != $past(tmr_status[6])) |-> $fell(tmr_status[7])); // R3
   AST_ALIGN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (!crc_mf_aligned && ms_tick) |=> tmr_status[3] != $past(tmr_status[3])); // R5
   AST_ALIGN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_mf_aligned && crc_mf_sync) |=> tmr_status[3]); // R6
   AST_SRCH8_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      srch8_expire |=> tmr_status[4] != $past(tmr_status[4])); // R7
   AST_SRCH400_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      srch400_expire |=> tmr_status[5] != $past(tmr_status[5])); // R7
   AST_KLVE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !ais_active |=> !tmr_status[2]); // R8
   AST_KLVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_status[2] |-> ais_run == KTOP); // R8
   AST_T1_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_status[0]) |-> !tmr_status[1]); // R9
   AST_T2_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      nonnormal_frame |=> !tmr_status[0]); // R10
endmodule

bind e1_maint_timer_status e1_maint_timer_status_chk #(.KA_MS(KA_MS)) u_chk (
   .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .freerun(freerun),
   .nonnormal_frame(nonnormal_frame), .ais_active(ais_active),
   .crc_mf_aligned(crc_mf_aligned), .crc_mf_sync(crc_mf_sync),
   .srch8_expire(srch8_expire), .srch400_expire(srch400_expire),
   .tmr_status(tmr_status)
);

// File: tb/e1_maint_timer_status_tb.sv
`timescale 1ns/1ps
module e1_maint_timer_status_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b0, freerun = 1'b0, frame_sync_ok = 1'b1;
   logic nonnormal_frame = 1'b1, ais_active = 1'b0;
   logic crc_mf_aligned = 1'b0, crc_mf_sync = 1'b0;
   logic srch8_expire = 1'b0, srch400_expire = 1'b0;
   logic [7:0] tmr_status;
   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   e1_maint_timer_status u_dut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .freerun(freerun),
      .frame_sync_ok(frame_sync_ok), .nonnormal_frame(nonnormal_frame),
      .ais_active(ais_active), .crc_mf_aligned(crc_mf_aligned),
      .crc_mf_sync(crc_mf_sync), .srch8_expire(srch8_expire),
      .srch400_expire(srch400_expire), .tmr_status(tmr_status)
   );

   task automatic chk_bit(input int idx, input logic exp, input string req);
      checks++;
      if (tmr_status[idx] !== exp) begin
         failures++;
         $display("FAIL %s bit%0d actual=%b expected=%b", req, idx, tmr_status[idx], exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) ms_tick = 1'b1;
         @(negedge clk) ms_tick = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      checks++;
      if (tmr_status !== 8'h00) begin
         failures++;
         $display("FAIL R1 status actual=%h expected=00", tmr_status);
      end
   endtask

   task automatic t_heartbeat();
      ticks(499);
      chk_bit(7, 1'b0, "R2 before 500");
      ticks(1);
      chk_bit(7, 1'b1, "R2 at 500");
      chk_bit(6, 1'b0, "R3 on rising one-sec");
      ticks(500);
      chk_bit(7, 1'b0, "R2 at 1000");
      chk_bit(6, 1'b1, "R3 at 1000");
   endtask

   task automatic t_freerun();
      logic [1:0] held;
      held = tmr_status[7:6];
      freerun = 1'b1;
      ticks(600);
      chk_bit(7, held[1], "R4 hold one-sec");
      chk_bit(6, held[0], "R4 hold two-sec");
      freerun = 1'b0;
      ticks(499);
      chk_bit(7, held[1], "R4 count held");
      ticks(1);
      chk_bit(7, ~held[1], "R4 resume");
   endtask

   task automatic t_search();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk) srch8_expire = 1'b1;
         @(negedge clk) srch8_expire = 1'b0;
         chk_bit(4, (i % 2 == 0), "R7 8ms toggle R11");
      end
      @(negedge clk) srch400_expire = 1'b1;
      @(negedge clk) srch400_expire = 1'b0;
      chk_bit(5, 1'b1, "R7 400ms toggle R11");
   endtask

   task automatic t_align();
      logic a;
      a = tmr_status[3];
      ticks(1);
      chk_bit(3, ~a, "R5 free toggle");
      ticks(1);
      chk_bit(3, a, "R5 free toggle back");
      crc_mf_aligned = 1'b1;
      if (tmr_status[3] == 1'b1) ticks(1);
      @(negedge clk) begin crc_mf_sync = 1'b1; ms_tick = 1'b1; end
      @(negedge clk) begin crc_mf_sync = 1'b0; ms_tick = 1'b0; end
      chk_bit(3, 1'b1, "R6 sync wins over tick");
      ticks(1);
      chk_bit(3, 1'b0, "R6 tick toggles");
      @(negedge clk) crc_mf_sync = 1'b1;
      @(negedge clk) crc_mf_sync = 1'b0;
      chk_bit(3, 1'b1, "R6 sync forces one");
      @(negedge clk) crc_mf_sync = 1'b1;
      @(negedge clk) crc_mf_sync = 1'b0;
      chk_bit(3, 1'b1, "R6 sync does not toggle");
      crc_mf_aligned = 1'b0;
   endtask

   task automatic t_keepalive();
      ais_active = 1'b1;
      ticks(99);
      chk_bit(2, 1'b0, "R8 before 100");
      ais_active = 1'b0;
      idle(1);
      ais_active = 1'b1;
      ticks(99);
      chk_bit(2, 1'b0, "R8 restart");
      ticks(1);
      chk_bit(2, 1'b1, "R8 set R11");
      ais_active = 1'b0;
      idle(1);
      chk_bit(2, 1'b0, "R8 clear");
   endtask

   task automatic t_timer_two();
      frame_sync_ok = 1'b1;
      nonnormal_frame = 1'b0;
      ticks(9);
      chk_bit(0, 1'b0, "R10 before 10");
      ticks(1);
      chk_bit(0, 1'b1, "R10 set R11");
      nonnormal_frame = 1'b1;
      idle(1);
      chk_bit(0, 1'b0, "R10 clear");
      nonnormal_frame = 1'b0;
      ticks(9);
      chk_bit(0, 1'b0, "R10 restart");
      nonnormal_frame = 1'b1;
      idle(1);
   endtask

   task automatic t_timer_one();
      nonnormal_frame = 1'b0;
      frame_sync_ok = 1'b0;
      ticks(99);
      chk_bit(1, 1'b0, "R9 before 100");
      frame_sync_ok = 1'b1;
      idle(1);
      frame_sync_ok = 1'b0;
      ticks(99);
      chk_bit(1, 1'b0, "R9 restart");
      ticks(1);
      chk_bit(1, 1'b1, "R9 set R11");
      frame_sync_ok = 1'b1;
      ticks(9);
      chk_bit(1, 1'b1, "R9 held before timer-two");
      chk_bit(0, 1'b0, "R10 not yet");
      ticks(1);
      chk_bit(0, 1'b1, "R10 set after sync");
      chk_bit(1, 1'b0, "R9 cleared by timer-two");
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle(3);
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      idle(1);
      t_reset();
      t_heartbeat();
      t_freerun();
      t_search();
      t_align();
      t_keepalive();
      t_timer_two();
      t_timer_one();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule